// File: doc/BRIEF.md
# Serial Control and Status Port

This block is the management port of a subscriber-loop transceiver. A host reaches it over four wires: an active-low select, a serial clock, a data input and a data output. Each access is a single byte exchange. While the host shifts a new control byte in, most significant bit first, the block shifts a status byte out in the same order. The control byte sets the transceiver role, power state, loopback options, the function of the D-channel clock pin and the swapping of the two B channels. The status byte combines a copy of the upper control bits with three line conditions.

The serial pins are brought into the system clock domain through a synchronizer. All decisions are taken on edges detected there. The status byte is frozen when select falls. A new control value is committed only when select rises after exactly eight clock pulses. Because every complete access writes the control register, a host that only wants to read status sends the current control byte back.

A latched interrupt, delivered as an active-high pull-down request for an open-drain pin, reports any change of the in-sync or signal-present inputs. It is released by the first serial clock pulse of the next access. Coding violations are collected in a sticky status bit that raises no interrupt and is cleared by each access.

Top module: `serial_ctrl_port`

## Requirements
- R1: After reset all eight control outputs are 0, the interrupt pull request is 0 and the data-out enable is 0.
- R2: A complete access commits the byte shifted in, first bit sent becoming bit 7. The control bits are mapped as follows: bit 7 selects slave (1) or master (0); bit 6 selects power-up; bit 5 selects digital loopback; bit 4 selects line loopback of all channels; bit 3 selects line loopback of B1; bit 2 selects line loopback of B2; bit 1 makes the D-clock pin an enable input; bit 0 exchanges B1 and B2.
- R3: The status byte leaves on the data output bit 7 first, one bit per serial clock falling edge. Bits 7 to 3 of the status byte equal control bits 7 to 3 as they stood when select fell.
- R4: The control register changes only when select rises after exactly 8 rising serial clock edges. An access with any other count leaves it unchanged, and serial clock activity while select is high has no effect.
- R5: Status bit 2 is 1 when a violation pulse arrived since the previous access began, and it is 0 otherwise. Each access clears it after capture, and a violation never raises the interrupt.
- R6: Status bit 1 reports the in-sync input and status bit 0 reports the signal-present input. A change of either input sets the interrupt pull request to 1.
- R7: The interrupt pull request returns to 0 after the first rising serial clock edge of an access, unless a new status change arrives.
- R8: The data-out enable is 1 while select is low and 0 while select is high.
- R9: The status byte is captured when select falls. Input changes during the transfer do not alter the bits shifted out, but a status change during the transfer still sets the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial select, active low, asynchronous to clk |
| sclk | input | 1 | Serial clock, asynchronous to clk |
| sdi | input | 1 | Serial data in, sampled on sclk rising |
| sdo | output | 1 | Serial data out, changes after sclk falling |
| sdo_en | output | 1 | Drive enable for sdo; low means high impedance |
| irq_pull | output | 1 | 1 requests the open-drain interrupt pin be pulled low |
| viol_pulse | input | 1 | One-cycle coding-violation event from the line codec |
| in_sync | input | 1 | Loop-synchronized level from the sync controller |
| sig_present | input | 1 | Line-signal-present level |
| role_slave | output | 1 | Control bit 7 |
| power_up | output | 1 | Control bit 6 |
| lb_digital | output | 1 | Control bit 5 |
| lb_line_all | output | 1 | Control bit 4 |
| lb_line_b1 | output | 1 | Control bit 3 |
| lb_line_b2 | output | 1 | Control bit 2 |
| dclk_enable_mode | output | 1 | Control bit 1 |
| swap_b | output | 1 | Control bit 0 |

## Verification
The bench sends accesses of five and nine pulses and toggles the serial clock with select high. A counter that commits on any rise of select, or that keeps counting while idle, would then corrupt the control outputs. It injects a violation before one read and checks that the following read returns bit 2 clear with no interrupt, which catches a sticky bit that never clears or one wired into the interrupt. It flips signal-present halfway through a transfer. A design that shifts live status would show the new level, and one that masks events during an access would lose the interrupt. The bench also probes the interrupt right after the first clock pulse of an access, so a release that waits for the end of the access is caught.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int BYTE_W  = 8;
  localparam int CB_SLV  = 7;
  localparam int CB_PWR  = 6;
  localparam int CB_LBD  = 5;
  localparam int CB_LBA  = 4;
  localparam int CB_LB1  = 3;
  localparam int CB_LB2  = 2;
  localparam int CB_DEN  = 1;
  localparam int CB_SWP  = 0;
  localparam int ECHO_LO = 3;
endpackage

// File: rtl/scp_pin_sync.sv
module scp_pin_sync #(
  parameter int STAGES = 2,
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] last;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      last <= RST_VAL;
    end else begin
      chain[0] <= pin;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      last <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~last;
  assign fall = ~lvl & last;
endmodule

// File: rtl/scp_shift_engine.sv
module scp_shift_engine #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_low,
  input  logic         cs_fall,
  input  logic         cs_rise,
  input  logic         sclk_rise,
  input  logic         sclk_fall,
  input  logic         sdi,
  input  logic [W-1:0] status_byte,
  output logic         sdo,
  output logic         sdo_en,
  output logic         wr_stb,
  output logic [W-1:0] wr_data,
  output logic         first_clk
);
  localparam int CNT_W = $clog2(W + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(W + 1);

  logic [W-1:0]     in_sr;
  logic [W-1:0]     out_sr;
  logic [CNT_W-1:0] cnt;
  logic             en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_sr  <= '0;
      out_sr <= '0;
      cnt    <= '0;
      en_q   <= 1'b0;
    end else if (cs_fall) begin
      out_sr <= status_byte;
      cnt    <= '0;
      en_q   <= 1'b1;
    end else if (cs_rise) begin
      en_q <= 1'b0;
    end else if (cs_low) begin
      if (sclk_rise) begin
        in_sr <= {in_sr[W-2:0], sdi};
        if (cnt != OVER) cnt <= cnt + 1'b1;
      end
      if (sclk_fall) out_sr <= {out_sr[W-2:0], 1'b0};
    end
  end

  assign sdo       = out_sr[W-1];
  assign sdo_en    = en_q;
  assign wr_stb    = cs_rise && (cnt == FULL);
  assign wr_data   = in_sr;
  assign first_clk = cs_low && sclk_rise && (cnt == '0);
endmodule

// File: rtl/scp_status_unit.sv
module scp_status_unit (
  input  logic       clk,
  input  logic       rst,
  input  logic       capture,
  input  logic       release_irq,
  input  logic       viol_pulse,
  input  logic [1:0] levels,
  output logic       viol_flag,
  output logic       irq
);
  logic [1:0] prev;
  logic       change;

  assign change = (levels != prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev      <= levels;
      viol_flag <= 1'b0;
      irq       <= 1'b0;
    end else begin
      prev <= levels;
      if (capture)         viol_flag <= viol_pulse;
      else if (viol_pulse) viol_flag <= 1'b1;
      if (change)           irq <= 1'b1;
      else if (release_irq) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_ctrl_port.sv
module serial_ctrl_port
  import scp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_en,
  output logic irq_pull,
  input  logic viol_pulse,
  input  logic in_sync,
  input  logic sig_present,
  output logic role_slave,
  output logic power_up,
  output logic lb_digital,
  output logic lb_line_all,
  output logic lb_line_b1,
  output logic lb_line_b2,
  output logic dclk_enable_mode,
  output logic swap_b
);
  localparam int PIN_W = 3;
  localparam int P_CS = 0;
  localparam int P_CK = 1;
  localparam int P_DI = 2;

  logic [PIN_W-1:0]  p_lvl, p_rise, p_fall;
  logic [BYTE_W-1:0] ctrl_q;
  logic [BYTE_W-1:0] status_byte;
  logic [BYTE_W-1:0] wr_data;
  logic              wr_stb, first_clk, viol_flag;

  scp_pin_sync #(
    .STAGES (SYNC_STAGES),
    .W      (PIN_W),
    .RST_VAL(PIN_W'(1) << P_CS)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .pin ({sdi, sclk, cs_n}),
    .lvl (p_lvl),
    .rise(p_rise),
    .fall(p_fall)
  );

  assign status_byte = {ctrl_q[BYTE_W-1:ECHO_LO], viol_flag, in_sync, sig_present};

  scp_shift_engine #(.W(BYTE_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .cs_low     (~p_lvl[P_CS]),
    .cs_fall    (p_fall[P_CS]),
    .cs_rise    (p_rise[P_CS]),
    .sclk_rise  (p_rise[P_CK]),
    .sclk_fall  (p_fall[P_CK]),
    .sdi        (p_lvl[P_DI]),
    .status_byte(status_byte),
    .sdo        (sdo),
    .sdo_en     (sdo_en),
    .wr_stb     (wr_stb),
    .wr_data    (wr_data),
    .first_clk  (first_clk)
  );

  scp_status_unit u_stat (
    .clk        (clk),
    .rst        (rst),
    .capture    (p_fall[P_CS]),
    .release_irq(first_clk),
    .viol_pulse (viol_pulse),
    .levels     ({in_sync, sig_present}),
    .viol_flag  (viol_flag),
    .irq        (irq_pull)
  );

  always_ff @(posedge clk) begin
    if (rst)         ctrl_q <= '0;
    else if (wr_stb) ctrl_q <= wr_data;
  end

  assign role_slave       = ctrl_q[CB_SLV];
  assign power_up         = ctrl_q[CB_PWR];
  assign lb_digital       = ctrl_q[CB_LBD];
  assign lb_line_all      = ctrl_q[CB_LBA];
  assign lb_line_b1       = ctrl_q[CB_LB1];
  assign lb_line_b2       = ctrl_q[CB_LB2];
  assign dclk_enable_mode = ctrl_q[CB_DEN];
  assign swap_b           = ctrl_q[CB_SWP];
endmodule

// File: rtl/serial_ctrl_port_chk.sv
module serial_ctrl_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       sdo,
  input logic       sdo_en,
  input logic       irq_pull,
  input logic       in_sync,
  input logic       sig_present,
  input logic [7:0] ctrl_q
);
  logic [1:0] lv;
  assign lv = {in_sync, sig_present};

  // R4: control changes only on the cycle the access closes
  a_r4_ctrl_only_at_close: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q != $past(ctrl_q)) |-> $fell(sdo_en));

  // R3: first bit driven equals control bit 7
  a_r3_first_bit_echo: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_en) |-> (sdo == ctrl_q[7]));

  // R6: interrupt rises only after a status level change
  a_r6_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_pull) |-> ($past(lv) != $past(lv, 2)));

  // R7: interrupt released only inside an access
  a_r7_release_in_access: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_pull) |-> $past(sdo_en));
endmodule

bind serial_ctrl_port serial_ctrl_port_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .sdo        (sdo),
  .sdo_en     (sdo_en),
  .irq_pull   (irq_pull),
  .in_sync    (in_sync),
  .sig_present(sig_present),
  .ctrl_q     (ctrl_q)
);

// File: tb/serial_ctrl_port_bench.sv
module serial_ctrl_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;
  localparam int LIMIT = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic viol_pulse = 1'b0, in_sync = 1'b0, sig_present = 1'b0;
  logic sdo, sdo_en, irq_pull;
  logic role_slave, power_up, lb_digital, lb_line_all, lb_line_b1, lb_line_b2;
  logic dclk_enable_mode, swap_b;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] rx = '0;
  int         nb = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_ctrl_port u_serial_ctrl_port (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en), .irq_pull(irq_pull),
    .viol_pulse(viol_pulse), .in_sync(in_sync), .sig_present(sig_present),
    .role_slave(role_slave), .power_up(power_up), .lb_digital(lb_digital),
    .lb_line_all(lb_line_all), .lb_line_b1(lb_line_b1), .lb_line_b2(lb_line_b2),
    .dclk_enable_mode(dclk_enable_mode), .swap_b(swap_b)
  );

  function automatic logic [7:0] ports();
    return {role_slave, power_up, lb_digital, lb_line_all,
            lb_line_b1, lb_line_b2, dclk_enable_mode, swap_b};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: assemble the byte seen on sdo and compare with the scoreboard
  always @(negedge cs_n) begin rx = '0; nb = 0; end
  always @(posedge sclk) if (!cs_n) begin rx = {rx[6:0], sdo}; nb++; end
  always @(posedge cs_n) begin
    if (nb == 8) begin
      if (exp_q.size() == 0) chk("R3 unexpected byte", rx, 8'hxx);
      else chk(tag_q.pop_front(), rx, exp_q.pop_front());
    end
  end

  task automatic xfer(input logic [7:0] b, input int nbits, input bit push,
                      input logic [7:0] exp, input string tag,
                      input bit mid_flip, input bit irq_probe);
    if (push) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    @(negedge clk) cs_n = 1'b0;
    repeat (H) @(negedge clk);
    chk("R8 enable in access", {7'd0, sdo_en}, 8'd1);
    for (int i = 0; i < nbits; i++) begin
      sdi = b[7 - (i % 8)];
      repeat (H) @(negedge clk);
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      if (i == 0 && irq_probe) chk("R7 irq after first clock", {7'd0, irq_pull}, 8'd0);
      if (i == 3 && mid_flip) sig_present = ~sig_present;
      sclk = 1'b0;
      repeat (H) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (H) @(negedge clk);
    chk("R8 enable idle", {7'd0, sdo_en}, 8'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (H) @(negedge clk);
    // R1 reset state
    chk("R1 control", ports(), 8'h00);
    chk("R1 irq", {7'd0, irq_pull}, 8'd0);
    chk("R1 enable", {7'd0, sdo_en}, 8'd0);

    // R2 and R3: two writes, status echoes previous control
    xfer(8'hA5, 8, 1, 8'h00, "R3 status after reset", 0, 0);
    chk("R2 fields A5", ports(), 8'hA5);
    xfer(8'h5A, 8, 1, 8'hA0, "R3 echo of A5", 0, 0);
    chk("R2 fields 5A", ports(), 8'h5A);

    // R4 wrong clock counts and idle clocks
    xfer(8'hFF, 5, 0, 8'h00, "", 0, 0);
    chk("R4 five pulses", ports(), 8'h5A);
    xfer(8'hFF, 9, 0, 8'h00, "", 0, 0);
    chk("R4 nine pulses", ports(), 8'h5A);
    sdi = 1'b1;
    for (int i = 0; i < 10; i++) begin
      repeat (H) @(negedge clk) sclk = 1'b1;
      repeat (H) @(negedge clk) sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    chk("R8 idle while clocking", {7'd0, sdo_en}, 8'd0);
    chk("R4 idle clocks", ports(), 8'h5A);
    xfer(8'h5A, 8, 1, 8'h58, "R4 readback", 0, 0);

    // R5 violation bit
    @(negedge clk) viol_pulse = 1'b1;
    @(negedge clk) viol_pulse = 1'b0;
    repeat (H) @(negedge clk);
    chk("R5 no irq on violation", {7'd0, irq_pull}, 8'd0);
    xfer(8'h5A, 8, 1, 8'h5C, "R5 violation reported", 0, 0);
    xfer(8'h5A, 8, 1, 8'h58, "R5 violation cleared", 0, 0);

    // R6 and R7 status levels and interrupt
    @(negedge clk) sig_present = 1'b1;
    repeat (H) @(negedge clk);
    chk("R6 irq on signal", {7'd0, irq_pull}, 8'd1);
    xfer(8'h5A, 8, 1, 8'h59, "R6 signal bit", 0, 1);
    chk("R7 irq released", {7'd0, irq_pull}, 8'd0);
    @(negedge clk) in_sync = 1'b1;
    repeat (H) @(negedge clk);
    chk("R6 irq on sync", {7'd0, irq_pull}, 8'd1);
    xfer(8'h5A, 8, 1, 8'h5B, "R6 sync bit", 0, 1);
    chk("R7 irq released again", {7'd0, irq_pull}, 8'd0);

    // R9 change during a transfer
    xfer(8'h5A, 8, 1, 8'h5B, "R9 frozen byte", 1, 0);
    chk("R9 irq from mid change", {7'd0, irq_pull}, 8'd1);
    xfer(8'h5A, 8, 1, 8'h5A, "R6 new level", 0, 1);
    chk("R7 irq cleared", {7'd0, irq_pull}, 8'd0);

    // R2 and R3 extremes
    xfer(8'hFF, 8, 1, 8'h5A, "R3 echo of 5A", 0, 0);
    chk("R2 all ones", ports(), 8'hFF);
    xfer(8'h00, 8, 1, 8'hFA, "R3 echo of FF", 0, 0);
    chk("R2 all zeros", ports(), 8'h00);

    repeat (H) @(negedge clk);
    if (exp_q.size() != 0) chk("R3 bytes missing", 8'(exp_q.size()), 8'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule